// File: doc/BRIEF.md
# Banked General-Purpose Pin Controller

This block gives software control over a parameterised set of pin banks, eight pins per bank, through a small 32-bit register bus. Each pin is owned either by a special-function source (another block on the chip) or by the GPIO registers. Under GPIO ownership, the pad's drive enable and drive level come from the bank's direction and level registers. The pad's input level is resynchronised and can always be read back.

Each bank has two write-only masked aliases, one for direction and one for level. A single bus write to an alias changes any subset of the bank's pins and leaves the others alone. The upper byte of the write data picks the pins to change, and the lower byte gives their new values. Several software agents can therefore each drive their own pins without a read-modify-write sequence and without any lock.

Banks sit in groups of four per 256-byte window. Bank k has its base at (k/4)*0x100 + (k%4)*4, and every register offset is added to that base. The bus read path is combinational. A write lands on the rising clock edge on which `bus_wr` is high.

Top module: `pinbank_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, every ownership, direction and level bit is 0. Every pin starts owned by its special-function source, and the GPIO driver is off.
- R2: Bank k (k < NUM_BANKS) answers at base (k/4)*0x100 + (k%4)*4. Its registers sit at these offsets from that base: ownership at 0x00, direction at 0x10, level at 0x20, pad input at 0x30, masked direction at 0x80 and masked level at 0xA0. Bits 31:8 of every read are 0.
- R3: A write to the masked direction alias sets direction bit n to write-data bit n only where write-data bit n+8 is 1. A direction bit of 1 turns the driver on, and 0 turns it off. Pins whose mask bit is 0 keep their direction.
- R4: A write to the masked level alias updates level bit n from write-data bit n only where write-data bit n+8 is 1. Every other level bit is unchanged.
- R5: When ownership bit n is 0, pad_out and pad_oe of that pin equal alt_out and alt_oe of that pin, whatever the direction and level registers hold.
- R6: When ownership bit n is 1, pad_out of that pin equals level bit n and pad_oe equals direction bit n.
- R7: The pad input register returns pad_in through two flops. A level applied before clock edge e is not visible at edge e. It reads back once edge e+1 has passed.
- R8: A read from any unmapped address returns 0, and a write to one changes no register. Unmapped addresses are: a bank index of NUM_BANKS or more, any address with bits 1:0 not zero, and any offset other than the six in R2.
- R9: Writes to the pad input register have no effect. The two masked aliases read as 0.
- R10: A plain write to the ownership, direction or level register replaces all eight bits with write-data bits 7:0. Bits 31:8 of the write data are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, acted on at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | NUM_BANKS*8 | Raw pad input levels, pin 8k+n is bank k pin n |
| pad_out | output | NUM_BANKS*8 | Level driven to each pad |
| pad_oe | output | NUM_BANKS*8 | Driver enable for each pad |
| alt_out | input | NUM_BANKS*8 | Special-function drive level per pin |
| alt_oe | input | NUM_BANKS*8 | Special-function driver enable per pin |

## Verification
The assertions assume that bus_addr, bus_wr and bus_wdata hold steady across each rising edge and change only between edges. They also assume that reset is held for at least one edge before any access. The properties about empty masks and unmapped writes take the decoder's hit signal as the reference for what counts as mapped. The bench drives every input one time unit after an edge, so each write sits on exactly one edge. It keeps the special-function and pad inputs constant across every check window, except in the synchroniser test, where the pad levels change on purpose.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
    localparam int PINS   = 8;
    localparam int ADDR_W = 12;
    localparam int BIDX_W = ADDR_W - 6;

    typedef logic [PINS-1:0] pin_vec_t;

    typedef enum logic [3:0] {
        SEL_OWN     = 4'h0,
        SEL_DIR     = 4'h1,
        SEL_LVL     = 4'h2,
        SEL_PAD     = 4'h3,
        SEL_DIR_MSK = 4'h8,
        SEL_LVL_MSK = 4'hA
    } reg_sel_e;

    typedef struct packed {
        logic              hit;
        logic [BIDX_W-1:0] bank;
        reg_sel_e          sel;
    } bus_dec_t;

    typedef struct packed {
        pin_vec_t own;
        pin_vec_t dir;
        pin_vec_t lvl;
    } bank_state_t;

    function automatic pin_vec_t merge_masked(pin_vec_t old, logic [31:0] wd);
        return (old & ~wd[15:8]) | (wd[7:0] & wd[15:8]);
    endfunction
endpackage

// File: rtl/gpb_decode.sv
module gpb_decode
    import gpb_pkg::*;
#(
    parameter int NUM_BANKS = 31
) (
    input  logic [ADDR_W-1:0] addr,
    output bus_dec_t          dec
);
    logic [BIDX_W-1:0] idx;
    logic              sel_ok;

    always_comb begin
        idx     = {addr[ADDR_W-1:8], addr[3:2]};
        sel_ok  = 1'b1;
        dec.sel = SEL_OWN;
        case (addr[7:4])
            4'h0:    dec.sel = SEL_OWN;
            4'h1:    dec.sel = SEL_DIR;
            4'h2:    dec.sel = SEL_LVL;
            4'h3:    dec.sel = SEL_PAD;
            4'h8:    dec.sel = SEL_DIR_MSK;
            4'hA:    dec.sel = SEL_LVL_MSK;
            default: sel_ok  = 1'b0;
        endcase
        dec.bank = idx;
        dec.hit  = sel_ok && (addr[1:0] == 2'b00) && (32'(idx) < 32'(NUM_BANKS));
    end
endmodule

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpb_bank.sv
module gpb_bank
    import gpb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  reg_sel_e    sel,
    input  logic [31:0] wdata,
    input  pin_vec_t    pad_sync,
    output bank_state_t state,
    output pin_vec_t    rd_byte
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_OWN:     state.own <= wdata[PINS-1:0];
                SEL_DIR:     state.dir <= wdata[PINS-1:0];
                SEL_LVL:     state.lvl <= wdata[PINS-1:0];
                SEL_DIR_MSK: state.dir <= merge_masked(state.dir, wdata);
                SEL_LVL_MSK: state.lvl <= merge_masked(state.lvl, wdata);
                default:     ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_OWN: rd_byte = state.own;
            SEL_DIR: rd_byte = state.dir;
            SEL_LVL: rd_byte = state.lvl;
            SEL_PAD: rd_byte = pad_sync;
            default: rd_byte = '0;
        endcase
    end
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import gpb_pkg::*;
#(
    parameter int NUM_BANKS = 31
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [11:0]               bus_addr,
    input  logic                      bus_wr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [NUM_BANKS*8-1:0]    pad_in,
    output logic [NUM_BANKS*8-1:0]    pad_out,
    output logic [NUM_BANKS*8-1:0]    pad_oe,
    input  logic [NUM_BANKS*8-1:0]    alt_out,
    input  logic [NUM_BANKS*8-1:0]    alt_oe
);
    localparam int NPINS = NUM_BANKS * PINS;

    bus_dec_t         dec;
    logic             dec_hit;
    logic [NPINS-1:0] pad_sync;
    logic [NPINS-1:0] own_all;
    logic [NPINS-1:0] dir_all;
    logic [NPINS-1:0] lvl_all;
    bank_state_t      st       [NUM_BANKS];
    pin_vec_t         rd_bytes [NUM_BANKS];

    gpb_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );
    assign dec_hit = dec.hit;

    gpb_sync #(.WIDTH(NPINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pad_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpb_bank u_bank (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (bus_wr && dec.hit && (dec.bank == BIDX_W'(b))),
            .sel      (dec.sel),
            .wdata    (bus_wdata),
            .pad_sync (pad_sync[b*PINS +: PINS]),
            .state    (st[b]),
            .rd_byte  (rd_bytes[b])
        );
        assign own_all[b*PINS +: PINS] = st[b].own;
        assign dir_all[b*PINS +: PINS] = st[b].dir;
        assign lvl_all[b*PINS +: PINS] = st[b].lvl;
    end

    assign pad_out = (own_all & lvl_all) | (~own_all & alt_out);
    assign pad_oe  = (own_all & dir_all) | (~own_all & alt_oe);

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (dec.hit && (dec.bank == BIDX_W'(b))) begin
                bus_rdata = {24'd0, rd_bytes[b]};
            end
        end
    end
endmodule

// File: rtl/gpb_checker.sv
module gpb_checker #(
    parameter int NPINS = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [11:0]      bus_addr,
    input logic             bus_wr,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic             hit,
    input logic [NPINS-1:0] own_all,
    input logic [NPINS-1:0] dir_all,
    input logic [NPINS-1:0] lvl_all,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe,
    input logic [NPINS-1:0] alt_out,
    input logic [NPINS-1:0] alt_oe
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (own_all == '0 && dir_all == '0 && lvl_all == '0));

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[31:8] == 24'd0);

    assert_empty_mask_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_wdata[15:8] == 8'd0 && bus_addr[7:4] == 4'h8) |=> $stable(dir_all));

    assert_empty_mask_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_wdata[15:8] == 8'd0 && bus_addr[7:4] == 4'hA) |=> $stable(lvl_all));

    assert_alt_owned_R5: assert property (@(posedge clk) disable iff (rst)
        (((pad_out ^ alt_out) & ~own_all) == '0) && (((pad_oe ^ alt_oe) & ~own_all) == '0));

    assert_gpio_owned_R6: assert property (@(posedge clk) disable iff (rst)
        (((pad_out ^ lvl_all) & own_all) == '0) && (((pad_oe ^ dir_all) & own_all) == '0));

    assert_unmapped_write_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !hit) |=> ($stable(own_all) && $stable(dir_all) && $stable(lvl_all)));

    assert_unmapped_read_R8: assert property (@(posedge clk) disable iff (rst)
        !hit |-> bus_rdata == 32'd0);
endmodule

bind pinbank_ctrl gpb_checker #(.NPINS($bits(pad_out))) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .hit       (dec_hit),
    .own_all   (own_all),
    .dir_all   (dir_all),
    .lvl_all   (lvl_all),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .alt_out   (alt_out),
    .alt_oe    (alt_oe)
);

// File: tb/test_pinbank_ctrl.sv
`timescale 1ns/1ps
module test_pinbank_ctrl;
    localparam int NB = 6;
    localparam int NP = NB * 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [11:0]   bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic [NP-1:0] alt_out = '0;
    logic [NP-1:0] alt_oe = '0;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_own [NB];
    logic [7:0] m_dir [NB];
    logic [7:0] m_lvl [NB];

    always #4 clk = ~clk;

    pinbank_ctrl #(.NUM_BANKS(NB)) i_pinbank_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .alt_out(alt_out), .alt_oe(alt_oe)
    );

    function automatic logic [11:0] badr(int k, int off);
        return 12'((k / 4) * 256 + (k % 4) * 4 + off);
    endfunction

    task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_write(logic [11:0] a, logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1;
        bus_wr    = 1'b0;
    endtask

    task automatic do_read(logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic verify_regs(string tag);
        logic [31:0] r;
        for (int k = 0; k < NB; k++) begin
            do_read(badr(k, 8'h00), r); check_eq({tag, " own"}, r, {24'd0, m_own[k]});
            do_read(badr(k, 8'h10), r); check_eq({tag, " dir"}, r, {24'd0, m_dir[k]});
            do_read(badr(k, 8'h20), r); check_eq({tag, " lvl"}, r, {24'd0, m_lvl[k]});
        end
    endtask

    task automatic verify_pads(string tag);
        for (int k = 0; k < NB; k++) begin
            check_eq({tag, " pad_out"}, {24'd0, pad_out[k*8 +: 8]},
                     {24'd0, (m_own[k] & m_lvl[k]) | (~m_own[k] & alt_out[k*8 +: 8])});
            check_eq({tag, " pad_oe"}, {24'd0, pad_oe[k*8 +: 8]},
                     {24'd0, (m_own[k] & m_dir[k]) | (~m_own[k] & alt_oe[k*8 +: 8])});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [NP-1:0] prev_pad;
        for (int k = 0; k < NB; k++) begin
            m_own[k] = '0; m_dir[k] = '0; m_lvl[k] = '0;
        end
        for (int i = 0; i < NP; i++) begin
            alt_out[i] = ((i * 7) % 3) == 0;
            alt_oe[i]  = ((i * 5) % 4) < 2;
        end
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R1: reset state, pads follow special-function sources
        verify_regs("R1 reset");
        verify_pads("R1 R5 reset pads");

        // R2 R10: plain writes with garbage upper bits, read back
        for (int k = 0; k < NB; k++) begin
            m_own[k] = 8'((k * 29 + 5) & 255);
            m_dir[k] = 8'((k * 53 + 11) & 255);
            m_lvl[k] = 8'((k * 71 + 200) & 255);
            do_write(badr(k, 8'h00), {24'hC3A5F0, m_own[k]});
            do_write(badr(k, 8'h10), {24'h5AFF12, m_dir[k]});
            do_write(badr(k, 8'h20), {24'hFFFFFF, m_lvl[k]});
        end
        verify_regs("R2 R10 plain");
        verify_pads("R5 R6 mixed");

        // R6: full GPIO ownership; R5: full special-function ownership
        for (int k = 0; k < NB; k++) begin
            m_own[k] = 8'hFF;
            do_write(badr(k, 8'h00), 32'hFF);
        end
        verify_pads("R6 gpio");
        for (int i = 0; i < NP; i++) begin
            alt_out[i] = ~alt_out[i];
            alt_oe[i]  = ~alt_oe[i];
        end
        #1;
        verify_pads("R6 gpio alt ignored");
        for (int k = 0; k < NB; k++) begin
            m_own[k] = 8'h00;
            do_write(badr(k, 8'h00), 32'h0);
        end
        verify_pads("R5 alt");

        // R3 R4: exhaustive mask sweep on last bank, alternating aliases
        for (int m = 0; m < 256; m++) begin
            logic [7:0] v;
            v = 8'((m * 13 + 7) & 255);
            if (m % 2 == 0) begin
                do_write(badr(NB - 1, 8'h80), {16'h0, 8'(m), v});
                m_dir[NB-1] = (m_dir[NB-1] & ~8'(m)) | (v & 8'(m));
                do_read(badr(NB - 1, 8'h10), r);
                check_eq("R3 masked dir", r, {24'd0, m_dir[NB-1]});
            end else begin
                do_write(badr(NB - 1, 8'hA0), {16'h0, 8'(m), v});
                m_lvl[NB-1] = (m_lvl[NB-1] & ~8'(m)) | (v & 8'(m));
                do_read(badr(NB - 1, 8'h20), r);
                check_eq("R4 masked lvl", r, {24'd0, m_lvl[NB-1]});
            end
        end
        // R3: single-pin set then clear of direction on bank 2, pin 3
        do_write(badr(2, 8'h80), 32'h0808);
        m_dir[2] = m_dir[2] | 8'h08;
        do_write(badr(2, 8'h80), 32'h0800);
        m_dir[2] = m_dir[2] & 8'hF7;
        m_own[2] = 8'hFF;
        do_write(badr(2, 8'h00), 32'hFF);
        verify_regs("R3 R4 after sweep");
        verify_pads("R3 R6 after sweep");

        // R9: masked aliases read 0, writes to pad input ignored
        do_read(badr(1, 8'h80), r); check_eq("R9 alias read dir", r, 32'd0);
        do_read(badr(1, 8'hA0), r); check_eq("R9 alias read lvl", r, 32'd0);
        for (int k = 0; k < NB; k++) do_write(badr(k, 8'h30), 32'hFFFF_FFFF);
        verify_regs("R9 input write");
        do_read(badr(0, 8'h30), r); check_eq("R9 input unchanged", r, 32'd0);

        // R7: two-flop latency over several pad patterns
        for (int p = 0; p < 5; p++) begin
            prev_pad = pad_in;
            for (int i = 0; i < NP; i++) pad_in[i] = ((i * (p + 3) + p) % 5) < 2;
            @(posedge clk); #1;
            for (int k = 0; k < NB; k++) begin
                do_read(badr(k, 8'h30), r);
                check_eq("R7 not yet", r, {24'd0, prev_pad[k*8 +: 8]});
            end
            @(posedge clk); #1;
            for (int k = 0; k < NB; k++) begin
                do_read(badr(k, 8'h30), r);
                check_eq("R7 visible", r, {24'd0, pad_in[k*8 +: 8]});
            end
        end

        // R8: unmapped bank index, offset, misalignment
        do_write(badr(NB, 8'h00), 32'hFF);
        do_write(badr(NB, 8'h20), 32'hFF);
        do_write(badr(0, 8'h40), 32'hFF);
        do_write(badr(1, 8'h90), 32'hFFFF);
        do_write(12'h001, 32'hFF);
        do_write(12'h012, 32'hFF);
        do_read(badr(NB, 8'h00), r); check_eq("R8 bank out of range", r, 32'd0);
        do_read(badr(0, 8'h40), r);  check_eq("R8 bad offset", r, 32'd0);
        do_read(12'h001, r);         check_eq("R8 misaligned", r, 32'd0);
        do_read(12'hF00, r);         check_eq("R8 top group", r, 32'd0);
        verify_regs("R8 after unmapped writes");
        verify_pads("R8 pads after unmapped writes");

        // R1: reset again clears everything
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        for (int k = 0; k < NB; k++) begin
            m_own[k] = '0; m_dir[k] = '0; m_lvl[k] = '0;
        end
        verify_regs("R1 second reset");
        verify_pads("R1 second reset pads");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule